// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the arithmetic and logic stage of a 32-bit datapath. Each cycle it receives a first operand, a second operand that has already been through a shifter, and the carry that shifter produced. It also receives a three-bit operation code and a set-flags enable. It drives the result combinationally from these inputs. It keeps a four-bit condition flag store (negative, zero, carry, overflow) and loads it on the rising clock edge when flag setting is enabled.

The five operations are bitwise AND, bitwise exclusive OR, add, subtract, and reverse subtract (second operand minus first). The arithmetic operations take their carry and overflow from the adder. The logical operations take their carry from the shifter input and leave overflow as it was. Choosing operands, writing results back and testing conditions are the job of the surrounding pipeline.

Top module: `flag_alu`

## Requirements
- R1: The operation code selects the result: 0 gives a AND b, 1 gives a XOR b, 2 gives a minus b, 3 gives b minus a, 4 gives a plus b. All results are taken modulo 2^32, and the result follows the inputs with no clock delay.
- R2: When the flags are updated, Z becomes 1 exactly when the 32-bit result is zero, and N becomes result bit 31. The updated flags are visible after the rising clock edge on which set_flags was high.
- R3: For add, C becomes the unsigned carry out of bit 31. V becomes 1 when a and b have the same sign and the result's sign differs from theirs.
- R4: For subtract, C becomes 1 when a is unsigned greater than or equal to b (no borrow). V becomes 1 when the signs of a and b differ and the result's sign differs from the sign of a.
- R5: For reverse subtract, the flags follow the subtract rules with b as the minuend and a as the subtrahend.
- R6: For AND and XOR, C is loaded from shift_c and V keeps its previous value.
- R7: With set_flags low, all four flags keep their values, and the result is still driven according to R1.
- R8: While rst_n is low, all four flags are 0.
- R9: Operation codes 5 to 7 drive a zero result and leave all four flags unchanged, even with set_flags high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Shifted second operand |
| shift_c | input | 1 | Carry out of the shifter |
| op_sel | input | 3 | Operation code |
| set_flags | input | 1 | Load the flag store on this edge |
| result | output | 32 | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench targets the carry sense of subtraction:
- Equal operands and a larger subtrahend must give C=1 and C=0 respectively. A design that reported a raw borrow would invert both.
- Reverse subtract with asymmetric operands exposes a design that computes the flags in the unswapped order.

Signed overflow is checked at both ends: 0x7FFFFFFF plus 1, and 0x80000000 minus 1. A wrong overflow term would miss one of them.

Three cases check that the flags hold:
- A logical operation issued right after an overflow must keep V at 1 and take C from shift_c, not from the adder.
- Cycles with set_flags low must not change the flags.
- Unused operation codes must not change the flags.

Randomised operand pairs then cover the ordinary results.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_XOR = 3'd1,
    OP_SUB = 3'd2,
    OP_RSB = 3'd3,
    OP_ADD = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] y_eff;
  logic [W:0]   wide;

  always_comb begin
    y_eff = sub ? ~y : y;
    wide  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, sub};
    sum   = wide[W-1:0];
    cout  = wide[W];
    // same-sign inputs to the adder with a different-sign sum
    ovf   = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_xor,
  output logic [W-1:0] y
);
  always_comb begin
    y = sel_xor ? (a ^ b) : (a & b);
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import flag_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  alu_flags_t d,
  output alu_flags_t q
);
  alu_flags_t q_nxt;

  always_comb begin
    q_nxt = en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         shift_c,
  input  logic [2:0]   op_sel,
  input  logic         set_flags,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);
  localparam int MSB = W - 1;

  logic [W-1:0] ar_x, ar_y, ar_sum, lg_y;
  logic         ar_sub, ar_cout, ar_ovf, upd;
  alu_flags_t   flg_q, flg_d;

  // reverse subtract feeds the operands to the adder swapped
  always_comb begin
    ar_x   = (op_sel == OP_RSB) ? op_b : op_a;
    ar_y   = (op_sel == OP_RSB) ? op_a : op_b;
    ar_sub = (op_sel == OP_SUB) || (op_sel == OP_RSB);
  end

  alu_arith #(.W(W)) u_arith (
    .x(ar_x), .y(ar_y), .sub(ar_sub),
    .sum(ar_sum), .cout(ar_cout), .ovf(ar_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .a(op_a), .b(op_b), .sel_xor(op_sel == OP_XOR), .y(lg_y)
  );

  always_comb begin
    result = '0;
    flg_d  = flg_q;
    upd    = 1'b0;
    case (op_sel)
      OP_AND, OP_XOR: begin
        result = lg_y;
        flg_d  = '{n: lg_y[MSB], z: (lg_y == '0), c: shift_c, v: flg_q.v};
        upd    = set_flags;
      end
      OP_SUB, OP_RSB, OP_ADD: begin
        result = ar_sum;
        flg_d  = '{n: ar_sum[MSB], z: (ar_sum == '0), c: ar_cout, v: ar_ovf};
        upd    = set_flags;
      end
      default: begin
        result = '0;
        upd    = 1'b0;
      end
    endcase
  end

  alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .en(upd), .d(flg_d), .q(flg_q)
  );

  assign flag_n = flg_q.n;
  assign flag_z = flg_q.z;
  assign flag_c = flg_q.c;
  assign flag_v = flg_q.v;

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable({flag_n, flag_z, flag_c, flag_v}));

  // R2
  zero_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_sel <= OP_ADD) |=>
      (flag_z == ($past(result) == '0)) && (flag_n == $past(result[MSB])));

  // R6
  logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_sel <= OP_XOR) |=>
      (flag_c == $past(shift_c)) && $stable(flag_v));

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > OP_ADD) |-> (result == '0) ##1 $stable({flag_n, flag_z, flag_c, flag_v}));
endmodule

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        shift_c = 1'b0, set_flags = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  flg;
    string       tag;
  } item_t;

  item_t      sb_q[$];
  logic [3:0] model_flg = 4'b0000; // {n,z,c,v}

  always #2.5 clk = ~clk;

  flag_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .shift_c(shift_c),
    .op_sel(op_sel), .set_flags(set_flags), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  // reference for the subtract rules: x minus y
  function automatic logic [4:0] sub_ref(input logic [31:0] x, input logic [31:0] y,
                                         output logic [31:0] r);
    r = x - y;
    return {1'b0, r[31], r == 0, x >= y, (x[31] != y[31]) && (r[31] != x[31])};
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic sc,
                       input logic [2:0] op, input logic sf, input string tag);
    item_t       it;
    logic [31:0] r;
    logic [3:0]  nf;
    logic [4:0]  t;
    logic [32:0] w;
    nf = model_flg;
    case (op)
      3'd0: begin r = a & b; nf = {r[31], r == 0, sc, model_flg[0]}; end
      3'd1: begin r = a ^ b; nf = {r[31], r == 0, sc, model_flg[0]}; end
      3'd2: begin t = sub_ref(a, b, r); nf = t[3:0]; end
      3'd3: begin t = sub_ref(b, a, r); nf = t[3:0]; end
      3'd4: begin
        w = {1'b0, a} + {1'b0, b};
        r = w[31:0];
        nf = {r[31], r == 0, w[32], (a[31] == b[31]) && (r[31] != a[31])};
      end
      default: r = '0;
    endcase
    if (sf && op <= 3'd4) model_flg = nf;
    @(negedge clk);
    op_a = a; op_b = b; shift_c = sc; op_sel = op; set_flags = sf;
    it.res = r; it.flg = model_flg; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: result from inputs driven at the last negedge, flags after this edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (result !== it.res) begin
          errors++;
          $display("FAIL %s result actual=%h expected=%h", it.tag, result, it.res);
        end
        checks++;
        if ({flag_n, flag_z, flag_c, flag_v} !== it.flg) begin
          errors++;
          $display("FAIL %s flags nzcv actual=%b expected=%b", it.tag,
                   {flag_n, flag_z, flag_c, flag_v}, it.flg);
        end
      end
    end
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R8 reset state
    if ({flag_n, flag_z, flag_c, flag_v} !== 4'b0000) begin
      errors++;
      $display("FAIL R8 flags actual=%b expected=0000", {flag_n, flag_z, flag_c, flag_v});
    end
    rst_n = 1'b1;

    drive(32'hF0F0_1234, 32'h0FF0_FFFF, 1'b0, 3'd0, 1'b1, "R1 and");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 3'd4, 1'b1, "R3 add overflow");
    drive(32'h8000_0001, 32'h8000_0000, 1'b1, 3'd0, 1'b1, "R6 and keeps V");
    drive(32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b0, 3'd1, 1'b1, "R2 xor zero");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 3'd4, 1'b1, "R3 add carry");
    drive(32'h0000_1000, 32'h0000_1000, 1'b0, 3'd2, 1'b1, "R4 sub equal");
    drive(32'h0000_0005, 32'h0000_0009, 1'b0, 3'd2, 1'b1, "R4 sub borrow");
    drive(32'h8000_0000, 32'h0000_0001, 1'b0, 3'd2, 1'b1, "R4 sub overflow");
    drive(32'h0000_0005, 32'h0000_0009, 1'b0, 3'd3, 1'b1, "R5 rsb");
    drive(32'h0000_0001, 32'h8000_0000, 1'b0, 3'd3, 1'b1, "R5 rsb overflow");
    drive(32'h1234_5678, 32'h1111_1111, 1'b1, 3'd4, 1'b0, "R7 hold add");
    drive(32'h0000_0000, 32'h0000_0000, 1'b0, 3'd1, 1'b0, "R7 hold xor");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 3'd5, 1'b1, "R9 op5");
    drive(32'h0000_0003, 32'h0000_0003, 1'b0, 3'd7, 1'b1, "R9 op7");
    drive(32'h0000_0000, 32'h0000_0001, 1'b1, 3'd1, 1'b1, "R6 xor carry");
    for (int i = 0; i < 200; i++) begin
      drive($urandom, $urandom, 1'($urandom), 3'($urandom % 6), 1'($urandom), "R1 random");
    end
    @(negedge clk);
    set_flags = 1'b0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule